// File: doc/BRIEF.md
# Byte-Wide Erasable Program Store with Programming Port

This block models an erasable, one-time-writable byte store that a larger design reads like an asynchronous PROM and writes through a narrow programming port. In read mode a full address selects a byte. The byte appears on the data output only while the active-low chip enable and the active-low output enable are both asserted. With chip enable released the outputs go quiet and the block drops into standby. After chip enable returns, a parameterised number of clock cycles passes before a read-valid flag rises.

In programming mode the address pins are shared. The upper address bits are captured from the lowest address lines by a latch strobe. The low eight bits come straight from the address lines. Two active-low strobes select the operation: program, verify (also used as blank check), or inhibit. A program operation can only clear bits, so each write ANDs the data into the stored byte. A bulk-erase pulse sweeps the whole array back to 0xFF over several cycles and holds a busy flag high while it runs. Reset starts the same sweep, so the array is erased when busy first falls. The high-impedance state of the data pins is shown by a separate drive-enable output, and the data output reads zero whenever that enable is low.

Top module: `eprom_store`

## Requirements
- R1: The store holds 2**ADDR_W bytes (default ADDR_W = 11, and 13 gives 8192). In read mode (prog_mode = 0) the byte is selected by all ADDR_W address bits.
- R2: In read mode with chip_en_n = 0 and out_en_n = 0, dout_oe is 1 and dout equals the stored byte at addr.
- R3: With chip_en_n = 1, dout_oe is 0 and dout is 0 whatever the other inputs are, and no byte is written.
- R4: In read mode with chip_en_n = 0 and out_en_n = 1, dout_oe is 0 and dout is 0.
- R5: In programming mode, a clock edge with latch_stb = 1 captures addr[ADDR_W-9:0] as address bits ADDR_W-1 down to 8. The effective address is {latched bits, addr[7:0]}. latch_stb has no effect in read mode.
- R6: In programming mode with chip_en_n = 0, pgm_n = 0 and vfy_n = 1 while busy is 0, the clock edge replaces the addressed byte with (old byte AND din).
- R7: In programming mode with chip_en_n = 0, vfy_n = 0 and pgm_n = 1, dout_oe is 1 and dout shows the stored byte, whatever out_en_n is. On an erased byte this reads 0xFF, which serves as the blank check.
- R8: In programming mode, pgm_n and vfy_n both 1, or both 0, leave dout_oe at 0 and write nothing.
- R9: standby is 1 exactly when chip_en_n was 1 at the last clock edge. rd_valid is 1 only while dout_oe is 1, busy is 0 and chip_en_n has been 0 for at least PWRUP_CYC consecutive edges.
- R10: erase_req = 1 at an edge while busy is 0 raises busy for exactly 2**ADDR_W / ERASE_LANES edges. When busy falls, every byte reads 0xFF. Reset starts the same sweep.
- R11: While busy is 1, program operations and further erase requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_mode | input | 1 | 1 selects the programming port, 0 selects read mode |
| chip_en_n | input | 1 | Active-low chip enable |
| out_en_n | input | 1 | Active-low output enable (read mode) |
| pgm_n | input | 1 | Active-low program strobe |
| vfy_n | input | 1 | Active-low verify strobe |
| latch_stb | input | 1 | Captures the upper address bits in programming mode |
| erase_req | input | 1 | Starts a bulk erase sweep |
| addr | input | ADDR_W | Address lines |
| din | input | 8 | Program data |
| dout | output | 8 | Read data, zero when not driven |
| dout_oe | output | 1 | Data drive enable; 0 stands for high impedance |
| rd_valid | output | 1 | Driven data is valid after power-up |
| standby | output | 1 | Low-power state indicator |
| busy | output | 1 | Erase sweep in progress |

## Verification
The assertions assume that the mode and strobe inputs are never unknown and hold steady across each sampled edge, and that PWRUP_CYC is at least one. The sweep-length check also assumes the array depth is a whole multiple of the lane count. The bench drives every input on the falling edge and samples a few nanoseconds after the rising edge. Each strobe combination it applies is therefore settled before the edge that acts on it. It only releases busy-sensitive stimulus once a sweep has been seen to end.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

  localparam int unsigned LOW_W  = 8;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_READ   = 2'd1,
    OP_PROG   = 2'd2,
    OP_VERIFY = 2'd3
  } op_e;

  function automatic op_e decode_op(input logic prog_mode, input logic ce_n,
                                    input logic oe_n, input logic pgm_n,
                                    input logic vfy_n);
    op_e op;
    op = OP_NONE;
    if (!ce_n) begin
      if (!prog_mode) begin
        if (!oe_n) op = OP_READ;
      end else begin
        case ({pgm_n, vfy_n})
          2'b01:   op = OP_PROG;
          2'b10:   op = OP_VERIFY;
          default: op = OP_NONE;
        endcase
      end
    end
    return op;
  endfunction

endpackage

// File: rtl/eprom_addr_path.sv
module eprom_addr_path #(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              prog_mode,
  input  logic              latch_stb,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] eff_addr
);
  import eprom_pkg::*;

  localparam int unsigned HI_W = ADDR_W - LOW_W;

  logic [HI_W-1:0] hi_q, hi_d;
  logic            hi_en;

  assign hi_en = prog_mode && latch_stb;

  always_comb begin
    hi_d = hi_q;
    if (hi_en) hi_d = addr[HI_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) hi_q <= '0;
    else         hi_q <= hi_d;
  end

  always_comb begin
    if (prog_mode) eff_addr = {hi_q, addr[LOW_W-1:0]};
    else           eff_addr = addr;
  end

endmodule

// File: rtl/eprom_power.sv
module eprom_power #(
  parameter int unsigned PWRUP_CYC = 4
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic chip_en_n,
  output logic powered,
  output logic standby
);
  localparam int unsigned CNT_W = $clog2(PWRUP_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(PWRUP_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (chip_en_n)             cnt_d = '0;
    else if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign powered = (cnt_q == CNT_MAX);
  assign standby = (cnt_q == '0);

endmodule

// File: rtl/eprom_erase_seq.sv
module eprom_erase_seq #(
  parameter int unsigned ADDR_W      = 11,
  parameter int unsigned ERASE_LANES = 8
) (
  input  logic                                     clk,
  input  logic                                     rst_ni,
  input  logic                                     erase_req,
  output logic                                     busy,
  output logic [ADDR_W-$clog2(ERASE_LANES)-1:0]    sweep_idx
);
  localparam int unsigned LANE_W = $clog2(ERASE_LANES);
  localparam int unsigned IDX_W  = ADDR_W - LANE_W;
  localparam logic [IDX_W-1:0] IDX_LAST = '1;

  logic             busy_q, busy_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    if (busy_q) begin
      idx_d = idx_q + 1'b1;
      if (idx_q == IDX_LAST) busy_d = 1'b0;
    end else if (erase_req) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end
  end

  // Reset enters the sweep so the array starts out erased.
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
    end
  end

  assign busy      = busy_q;
  assign sweep_idx = idx_q;

endmodule

// File: rtl/eprom_array.sv
module eprom_array #(
  parameter int unsigned ADDR_W      = 11,
  parameter int unsigned ERASE_LANES = 8
) (
  input  logic                                  clk,
  input  logic                                  we,
  input  logic [ADDR_W-1:0]                     waddr,
  input  logic [eprom_pkg::DATA_W-1:0]          wdata,
  input  logic                                  erase_en,
  input  logic [ADDR_W-$clog2(ERASE_LANES)-1:0] erase_idx,
  input  logic [ADDR_W-1:0]                     raddr,
  output logic [eprom_pkg::DATA_W-1:0]          rdata
);
  import eprom_pkg::*;

  localparam int unsigned DEPTH  = 1 << ADDR_W;
  localparam int unsigned LANE_W = $clog2(ERASE_LANES);

  logic [DATA_W-1:0] mem [DEPTH];

  // Storage carries no reset; the erase sweep after reset defines it.
  always_ff @(posedge clk) begin
    if (erase_en) begin
      for (int l = 0; l < int'(ERASE_LANES); l++) begin
        mem[{erase_idx, LANE_W'(l)}] <= '1;
      end
    end else if (we) begin
      mem[waddr] <= mem[waddr] & wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/eprom_store.sv
module eprom_store #(
  parameter int unsigned ADDR_W      = 11,
  parameter int unsigned PWRUP_CYC   = 4,
  parameter int unsigned ERASE_LANES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_mode,
  input  logic              chip_en_n,
  input  logic              out_en_n,
  input  logic              pgm_n,
  input  logic              vfy_n,
  input  logic              latch_stb,
  input  logic              erase_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_oe,
  output logic              rd_valid,
  output logic              standby,
  output logic              busy
);
  import eprom_pkg::*;

  localparam int unsigned LANE_W    = $clog2(ERASE_LANES);
  localparam int unsigned IDX_W     = ADDR_W - LANE_W;
  localparam int unsigned SWEEP_CYC = (1 << ADDR_W) / ERASE_LANES;

  logic [1:0]        rst_sync_q;
  logic              rst_ni;
  logic [ADDR_W-1:0] eff_addr;
  logic              powered;
  logic [IDX_W-1:0]  sweep_idx;
  logic [7:0]        rdata;
  logic              wr_en;
  logic              drive;
  op_e               op;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  assign op    = decode_op(prog_mode, chip_en_n, out_en_n, pgm_n, vfy_n);
  assign wr_en = (op == OP_PROG) && !busy;
  assign drive = (op == OP_READ) || (op == OP_VERIFY);

  eprom_addr_path #(.ADDR_W(ADDR_W)) u_addr (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .prog_mode (prog_mode),
    .latch_stb (latch_stb),
    .addr      (addr),
    .eff_addr  (eff_addr)
  );

  eprom_power #(.PWRUP_CYC(PWRUP_CYC)) u_power (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .chip_en_n (chip_en_n),
    .powered   (powered),
    .standby   (standby)
  );

  eprom_erase_seq #(.ADDR_W(ADDR_W), .ERASE_LANES(ERASE_LANES)) u_erase (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .erase_req (erase_req),
    .busy      (busy),
    .sweep_idx (sweep_idx)
  );

  eprom_array #(.ADDR_W(ADDR_W), .ERASE_LANES(ERASE_LANES)) u_array (
    .clk       (clk),
    .we        (wr_en),
    .waddr     (eff_addr),
    .wdata     (din),
    .erase_en  (busy),
    .erase_idx (sweep_idx),
    .raddr     (eff_addr),
    .rdata     (rdata)
  );

  assign dout_oe  = drive;
  assign dout     = drive ? rdata : 8'h00;
  assign rd_valid = drive && powered && !busy;

endmodule

// File: rtl/eprom_store_chk.sv
module eprom_store_chk #(
  parameter int unsigned SWEEP_CYC = 256
) (
  input logic clk,
  input logic rst_ni,
  input logic prog_mode,
  input logic chip_en_n,
  input logic out_en_n,
  input logic pgm_n,
  input logic vfy_n,
  input logic dout_oe,
  input logic rd_valid,
  input logic standby,
  input logic busy
);
  localparam int unsigned BC_W = $clog2(SWEEP_CYC + 1);
  localparam logic [BC_W-1:0] BC_LIM = BC_W'(SWEEP_CYC);

  logic [BC_W-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)  busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  p_ce_high_quiet_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    chip_en_n |-> !dout_oe);

  p_oe_gate_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (!prog_mode && !chip_en_n && out_en_n) |-> !dout_oe);

  p_inhibit_quiet_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (prog_mode && !chip_en_n && (pgm_n == vfy_n)) |-> !dout_oe);

  p_standby_track_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    $past(chip_en_n) |-> standby);

  p_valid_powered_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    rd_valid |-> (dout_oe && !standby && !busy));

  p_sweep_len_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    busy |-> (busy_cnt < BC_LIM));

endmodule

bind eprom_store eprom_store_chk #(.SWEEP_CYC(SWEEP_CYC)) u_chk (
  .clk       (clk),
  .rst_ni    (rst_ni),
  .prog_mode (prog_mode),
  .chip_en_n (chip_en_n),
  .out_en_n  (out_en_n),
  .pgm_n     (pgm_n),
  .vfy_n     (vfy_n),
  .dout_oe   (dout_oe),
  .rd_valid  (rd_valid),
  .standby   (standby),
  .busy      (busy)
);

// File: tb/eprom_store_bench.sv
module eprom_store_bench;

  localparam int AW    = 11;
  localparam int PWRUP = 4;
  localparam int LANES = 8;
  localparam int SWEEP = (1 << AW) / LANES;

  typedef struct packed {
    logic        pm;
    logic        ce_n;
    logic        oe_n;
    logic        pgm_n;
    logic        vfy_n;
    logic        lat;
    logic [10:0] a;
    logic [7:0]  d;
    logic        e_oe;
    logic [7:0]  e_do;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,11'h123,8'h00,1'b1,8'hFF}, // R2 erased read
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,11'h123,8'h00,1'b0,8'h00}, // R4
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,11'h123,8'h00,1'b0,8'h00}, // R3
    '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,11'h005,8'h00,1'b0,8'h00}, // R5 latch 5, R8
    '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,11'h0A5,8'h3C,1'b0,8'h00}, // R6 write
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,11'h0A5,8'h00,1'b1,8'h3C}, // R7 verify
    '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,11'h0A5,8'hF0,1'b0,8'h00}, // R6 second write
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,11'h0A5,8'h00,1'b1,8'h30}, // R6 AND result
    '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,11'h002,8'h00,1'b0,8'h00}, // R5 latch 2
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,11'h0A5,8'h00,1'b1,8'hFF}, // R7 blank check
    '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,11'h5A5,8'h00,1'b1,8'h30}, // R1 full address
    '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,11'h2A5,8'h00,1'b1,8'hFF}, // R1
    '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,11'h0A5,8'h00,1'b0,8'h00}, // R3 no write
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,11'h0A5,8'h00,1'b0,8'h00}, // R8 both low
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,11'h0A5,8'h00,1'b1,8'hFF}, // R8 unchanged
    '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,11'h005,8'h00,1'b1,8'hFF}, // R5 latch in read
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,11'h0A5,8'h00,1'b1,8'hFF}, // R5 upper still 2
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,11'h0A5,8'h00,1'b1,8'hFF}  // R7 oe ignored
  };

  function automatic string row_tag(input int r);
    case (r)
      0:          return "R2";
      1:          return "R4";
      2, 12:      return "R3";
      3, 8, 15, 16: return "R5";
      4, 6, 7:    return "R6";
      5, 9, 17:   return "R7";
      10, 11:     return "R1";
      default:    return "R8";
    endcase
  endfunction

  logic          clk = 1'b0;
  logic          rst_n;
  logic          prog_mode, chip_en_n, out_en_n, pgm_n, vfy_n, latch_stb, erase_req;
  logic [AW-1:0] addr;
  logic [7:0]    din;
  logic [7:0]    dout;
  logic          dout_oe, rd_valid, standby, busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  eprom_store #(.ADDR_W(AW), .PWRUP_CYC(PWRUP), .ERASE_LANES(LANES)) u_eprom_store (
    .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .chip_en_n(chip_en_n),
    .out_en_n(out_en_n), .pgm_n(pgm_n), .vfy_n(vfy_n), .latch_stb(latch_stb),
    .erase_req(erase_req), .addr(addr), .din(din), .dout(dout),
    .dout_oe(dout_oe), .rd_valid(rd_valid), .standby(standby), .busy(busy)
  );

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic pm, input logic ce, input logic oe,
                       input logic pg, input logic vf, input logic lt,
                       input logic [AW-1:0] a, input logic [7:0] d);
    prog_mode = pm; chip_en_n = ce; out_en_n = oe;
    pgm_n = pg; vfy_n = vf; latch_stb = lt; addr = a; din = d;
  endtask

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 4 * SWEEP) begin
      @(negedge clk);
      tick();
      n++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0;
    erase_req = 1'b0;
    drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, '0, 8'h00);
    repeat (3) tick();
    // Reset state: R3 quiet outputs, R10 sweep pending, R9 standby
    check("R3", "reset dout_oe", {7'd0, dout_oe}, 8'h00);
    check("R10", "reset busy", {7'd0, busy}, 8'h01);
    check("R9", "reset standby", {7'd0, standby}, 8'h01);
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    wait_idle(n);
    check("R10", "reset sweep ends", {7'd0, busy}, 8'h00);

    // Vector table
    for (int r = 0; r < NV; r++) begin
      @(negedge clk);
      drive(TBL[r].pm, TBL[r].ce_n, TBL[r].oe_n, TBL[r].pgm_n, TBL[r].vfy_n,
            TBL[r].lat, TBL[r].a, TBL[r].d);
      tick();
      check(row_tag(r), $sformatf("row %0d dout_oe", r), {7'd0, dout_oe}, {7'd0, TBL[r].e_oe});
      check(row_tag(r), $sformatf("row %0d dout", r), dout, TBL[r].e_do);
    end

    // R9 power-up delay
    @(negedge clk);
    drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 11'h5A5, 8'h00);
    tick();
    check("R9", "standby with ce high", {7'd0, standby}, 8'h01);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 11'h5A5, 8'h00);
    for (int k = 1; k <= PWRUP + 1; k++) begin
      tick();
      check("R9", $sformatf("rd_valid after %0d edges", k), {7'd0, rd_valid},
            (k >= PWRUP) ? 8'h01 : 8'h00);
      if (k == 1) check("R9", "standby falls", {7'd0, standby}, 8'h00);
      @(negedge clk);
    end
    check("R2", "powered read data", dout, 8'h30);
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 11'h5A5, 8'h00);
    tick();
    check("R9", "rd_valid drops", {7'd0, rd_valid}, 8'h00);
    check("R9", "standby returns", {7'd0, standby}, 8'h01);

    // Latch upper bits 0 before the erase
    @(negedge clk);
    drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 11'h000, 8'h00);
    tick();

    // R10 sweep length with R11 program attempt during busy
    @(negedge clk);
    drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 11'h000, 8'h00);
    erase_req = 1'b1;
    tick();
    n = busy ? 1 : 0;
    for (int i = 0; i < 4 * SWEEP && busy; i++) begin
      @(negedge clk);
      erase_req = (i == 6); // R11 second request while busy
      if (i == 3) drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 11'h000, 8'h00);
      else        drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 11'h000, 8'h00);
      tick();
      if (busy) n++;
    end
    erase_req = 1'b0;
    check("R10", "sweep length", n[7:0] ^ 8'(n >> 8), 8'(SWEEP) ^ 8'(SWEEP >> 8));
    check("R11", "busy held once after re-request", {7'd0, busy}, 8'h00);

    @(negedge clk);
    drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 11'h000, 8'h00);
    tick();
    check("R11", "write during busy ignored", dout, 8'hFF);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 11'h5A5, 8'h00);
    tick();
    check("R10", "programmed byte erased", dout, 8'hFF);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 11'h7FF, 8'h00);
    tick();
    check("R10", "last byte erased", dout, 8'hFF);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule